// File: doc/BRIEF.md
# Isolator Loopback Self-Test with Two-Stage Delay Measurement

The block proves that a signal isolator is alive. It drives a programmable bit sequence onto the isolator input, watches the signal that comes back through the isolator, and gives a verdict on the whole run. Along the way it measures how long each transition takes to cross the isolator. Rising and falling transitions are measured separately, and the worst of the two is reported.

The delay search has two stages. The coarse stage counts whole clock cycles from the excitation edge until the returned edge appears. The fine stage then resolves where that edge fell inside its cycle, using a vector of sub-cycle samples of the return line. An external multi-phase sampler, for example a tap chain or a set of phase-shifted enables, supplies that vector. The samples pass through a two-flop synchroniser, and its fixed latency is removed from the result.

A run is made of `PAT_W+1` slots, each `cfg_period` cycles long. The first slot always drives 0 so that the line starts from a known level. Each later slot drives one pattern bit.

Top module: `iso_selftest`

## Requirements
- R1: After reset, `excite_o`, `busy_o`, `done_o` and `pass_o` are 0, and all three delay outputs are 0.
- R2: A `start` seen while idle begins a run of `PAT_W+1` slots, each `cfg_period` cycles long. Slot 0 drives 0 on `excite_o`, and slot i (i ≥ 1) drives `cfg_pattern[i-1]`, so bit 0 goes first. `done_o` is a one-cycle pulse that appears `(PAT_W+1)*cfg_period + 1` cycles after the clock edge that took `start`.
- R3: While a run is busy, `start` is ignored. The configuration inputs are latched when the run starts, so changing them during the run has no effect on it.
- R4: `loop_taps[k]` is the return line sampled at offset k/NPH of a clock period, so bit NPH-1 is the latest sample. Consider a line that follows each excitation change after D sub-cycle units: tap k in cycle n equals the excitation level of cycle floor((n·NPH+k−D)/NPH). For such a line the measured delay for that polarity is D, in units of 1/NPH cycle.
- R5: `delay_rise_o` is the largest delay measured on 0→1 edges and `delay_fall_o` the largest on 1→0 edges. Each is 0 when no edge of that polarity occurred. `delay_o` is the larger of the two.
- R6: If the returned edge has not appeared by the last cycle of its slot, the run fails. This happens when floor(D/NPH)+2 > `cfg_period`−1.
- R7: Outside the wait for a pending edge, any tap that differs from the level being driven fails the run. This catches an inverted return line and glitches.
- R8: `pass_o` is 1 only when the run had no timeout and no mismatch, at least one edge was driven, and `cfg_lim_lo` ≤ `delay_o` ≤ `cfg_lim_hi`.
- R9: `excite_o` changes only in the first cycle of a slot.
- R10: `pass_o` and the delay outputs change only together with `done_o`, and otherwise hold until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a self-test run (honoured when idle) |
| cfg_pattern | input | PAT_W | Excitation bits, bit 0 driven first |
| cfg_period | input | PER_W | Slot length in clock cycles |
| cfg_lim_lo | input | DW | Lowest acceptable worst-case delay |
| cfg_lim_hi | input | DW | Highest acceptable worst-case delay |
| excite_o | output | 1 | Excitation to the isolator input |
| loop_taps | input | NPH | Sub-cycle samples of the isolator output |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| pass_o | output | 1 | Verdict of the last run |
| delay_o | output | DW | Worst-case delay, 1/NPH cycle units |
| delay_rise_o | output | DW | Worst rising-edge delay |
| delay_fall_o | output | DW | Worst falling-edge delay |

## Verification
The assertions check on every cycle that:
- the excitation moves only at slot starts,
- the slot counter stays below the latched period,
- `done_o` lasts a single cycle,
- the verdict changes only with `done_o`,
- the per-polarity maxima never shrink within a run.

The exact delay arithmetic can only be shown by the bench's scenarios. Those scenarios cover sync-latency removal, the fine thermometer count, the asymmetric rise and fall paths, the timeout boundary, the limit comparisons and the detection of inverted, stuck or glitching lines. The bench models an isolator with programmable rise and fall delays and sweeps those delays and every pattern.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } iso_state_e;
endpackage

// File: rtl/iso_sync.sv
module iso_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/iso_fine_count.sv
module iso_fine_count #(
  parameter int NPH = 4,
  localparam int FW = $clog2(NPH + 1)
) (
  input  logic [NPH-1:0] taps,
  input  logic           level,
  output logic [FW-1:0]  old_cnt,
  output logic           any_new,
  output logic           all_new
);
  logic [NPH-1:0] same;

  assign same    = ~(taps ^ {NPH{level}});
  assign any_new = |same;
  assign all_new = &same;

  always_comb begin
    old_cnt = '0;
    for (int k = 0; k < NPH; k++) begin
      old_cnt = old_cnt + FW'(!same[k]);
    end
  end
endmodule

// File: rtl/iso_delay_track.sv
module iso_delay_track #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic          is_rise,
  input  logic [DW-1:0] val,
  output logic [DW-1:0] rise_max,
  output logic [DW-1:0] fall_max,
  output logic          rise_seen,
  output logic          fall_seen
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rise_max  <= '0;
      fall_max  <= '0;
      rise_seen <= 1'b0;
      fall_seen <= 1'b0;
    end else if (upd) begin
      if (is_rise) begin
        rise_seen <= 1'b1;
        if (val > rise_max) rise_max <= val;
      end else begin
        fall_seen <= 1'b1;
        if (val > fall_max) fall_max <= val;
      end
    end
  end

  // R5
  rise_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> rise_max >= $past(rise_max));
  // R5
  fall_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> fall_max >= $past(fall_max));
endmodule

// File: rtl/iso_selftest.sv
module iso_selftest
  import iso_pkg::*;
#(
  parameter int NPH   = 4,
  parameter int PAT_W = 8,
  parameter int PER_W = 8,
  parameter int SYNC  = 2,
  localparam int DW   = PER_W + $clog2(NPH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAT_W-1:0] cfg_pattern,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [DW-1:0]    cfg_lim_lo,
  input  logic [DW-1:0]    cfg_lim_hi,
  output logic             excite_o,
  input  logic [NPH-1:0]   loop_taps,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [DW-1:0]    delay_o,
  output logic [DW-1:0]    delay_rise_o,
  output logic [DW-1:0]    delay_fall_o
);
  localparam int IW = $clog2(PAT_W + 1);
  localparam int FW = $clog2(NPH + 1);

  iso_state_e       state;
  logic [PER_W-1:0] scnt, per_q;
  logic [IW-1:0]    idx;
  logic [PAT_W-1:0] pat_sh;
  logic [DW-1:0]    lo_q, hi_q;
  logic             armed, err;

  logic [NPH-1:0]   taps_s;
  logic [FW-1:0]    old_cnt;
  logic             any_new, all_new;
  logic [DW-1:0]    rise_max, fall_max, worst, meas;
  logic             rise_seen, fall_seen;
  logic             run, det, early, slot_end, tmo, mism, upd, clr;

  iso_sync #(.W(NPH), .STAGES(SYNC)) i_sync (
    .clk(clk), .rst(rst), .d(loop_taps), .q(taps_s)
  );

  iso_fine_count #(.NPH(NPH)) i_fine (
    .taps(taps_s), .level(excite_o),
    .old_cnt(old_cnt), .any_new(any_new), .all_new(all_new)
  );

  // coarse stage: slot cycle count; fine stage: taps still at old level
  assign run      = (state == ST_RUN);
  assign slot_end = (scnt == per_q - PER_W'(1));
  assign det      = run && armed && any_new;
  assign early    = det && (scnt < PER_W'(SYNC));
  assign upd      = det && !early;
  assign tmo      = run && armed && !any_new && slot_end;
  assign mism     = run && !armed && !all_new;
  assign meas     = DW'(scnt - PER_W'(SYNC)) * DW'(NPH) + DW'(old_cnt);
  assign clr      = (state == ST_IDLE) && start;
  assign worst    = (rise_max > fall_max) ? rise_max : fall_max;

  iso_delay_track #(.DW(DW)) i_track (
    .clk(clk), .rst(rst), .clear(clr), .upd(upd), .is_rise(excite_o),
    .val(meas), .rise_max(rise_max), .fall_max(fall_max),
    .rise_seen(rise_seen), .fall_seen(fall_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      scnt         <= '0;
      per_q        <= '0;
      idx          <= '0;
      pat_sh       <= '0;
      lo_q         <= '0;
      hi_q         <= '0;
      armed        <= 1'b0;
      err          <= 1'b0;
      excite_o     <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      pass_o       <= 1'b0;
      delay_o      <= '0;
      delay_rise_o <= '0;
      delay_fall_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            busy_o   <= 1'b1;
            pat_sh   <= cfg_pattern;
            per_q    <= cfg_period;
            lo_q     <= cfg_lim_lo;
            hi_q     <= cfg_lim_hi;
            scnt     <= '0;
            idx      <= '0;
            err      <= 1'b0;
            excite_o <= 1'b0;
            armed    <= excite_o;
          end
        end
        ST_RUN: begin
          if (det) armed <= 1'b0;
          err <= err | tmo | mism | early;
          if (slot_end) begin
            if (idx == IW'(PAT_W)) begin
              state <= ST_FIN;
            end else begin
              idx      <= idx + IW'(1);
              excite_o <= pat_sh[0];
              armed    <= (pat_sh[0] != excite_o);
              pat_sh   <= pat_sh >> 1;
              scnt     <= '0;
            end
          end else begin
            scnt <= scnt + PER_W'(1);
          end
        end
        default: begin
          state        <= ST_IDLE;
          busy_o       <= 1'b0;
          done_o       <= 1'b1;
          pass_o       <= !err && (rise_seen || fall_seen) &&
                          (worst >= lo_q) && (worst <= hi_q);
          delay_o      <= worst;
          delay_rise_o <= rise_max;
          delay_fall_o <= fall_max;
        end
      endcase
    end
  end

  // R9
  excite_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(excite_o) |-> (scnt == '0));
  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && per_q != '0) |-> (scnt < per_q));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(pass_o) || !$stable(delay_o)) |-> done_o);
endmodule

// File: tb/test_iso_selftest.sv
`timescale 1ns/1ps
module test_iso_selftest;
  localparam int NPH = 4, PAT_W = 8, PER_W = 8, DW = PER_W + 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PAT_W-1:0] cfg_pattern = '0;
  logic [PER_W-1:0] cfg_period = 8'd8;
  logic [DW-1:0] cfg_lim_lo = '0, cfg_lim_hi = '1;
  logic excite_o, busy_o, done_o, pass_o;
  logic [NPH-1:0] loop_taps;
  logic [DW-1:0] delay_o, delay_rise_o, delay_fall_o;

  int checks = 0, errors = 0, cyc = 0;
  int d_rise = 0, d_fall = 0, fault = 0, glitch_at = -1;
  bit hist [256];

  always #2.5 clk = ~clk;

  iso_selftest #(.NPH(NPH), .PAT_W(PAT_W), .PER_W(PER_W)) i_iso_selftest (
    .clk(clk), .rst(rst), .start(start), .cfg_pattern(cfg_pattern),
    .cfg_period(cfg_period), .cfg_lim_lo(cfg_lim_lo), .cfg_lim_hi(cfg_lim_hi),
    .excite_o(excite_o), .loop_taps(loop_taps), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .delay_o(delay_o),
    .delay_rise_o(delay_rise_o), .delay_fall_o(delay_fall_o)
  );

  function automatic bit xat(int t);
    if (t < 0) return 1'b0;
    return hist[(t / NPH) % 256];
  endfunction

  // isolator model: separate rise and fall delays in 1/NPH cycle units
  initial begin
    loop_taps = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      hist[cyc % 256] = excite_o;
      for (int k = 0; k < NPH; k++) begin
        automatic int t = cyc * NPH + k;
        automatic bit a = xat(t - d_rise);
        automatic bit b = xat(t - d_fall);
        automatic bit ln = (d_rise >= d_fall) ? (a & b) : (a | b);
        if (fault == 1) ln = 1'b0;
        if (fault == 2) ln = ~ln;
        if (fault == 3 && cyc == glitch_at) ln = ~ln;
        loop_taps[k] = ln;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_test(input logic [7:0] pat, input int per, input int lo,
                          input int hi, input int dr, input int df,
                          input int fmode, input bit poke);
    bit lv [PAT_W+1];
    bit rs = 0, fs = 0, tmo = 0, pexp, seq_ok = 1, prev;
    int wexp, n = 0, nn = (PAT_W + 1) * per, rexp, fexp, p_keep, d_keep;
    fault = 0;
    repeat (40) @(posedge clk);
    d_rise = dr; d_fall = df; fault = fmode;
    #1;
    prev = excite_o;
    lv[0] = 1'b0;
    for (int i = 1; i <= PAT_W; i++) lv[i] = pat[i-1];
    if (prev && !lv[0]) fs = 1;
    for (int i = 1; i <= PAT_W; i++) begin
      if (!lv[i-1] && lv[i]) rs = 1;
      if (lv[i-1] && !lv[i]) fs = 1;
    end
    if (rs && (dr / NPH + 2 > per - 1)) tmo = 1;
    if (fs && (df / NPH + 2 > per - 1)) tmo = 1;
    rexp = rs ? dr : 0;
    fexp = fs ? df : 0;
    wexp = (rexp > fexp) ? rexp : fexp;
    pexp = !tmo && (fmode == 0) && (rs || fs) && (wexp >= lo) && (wexp <= hi);
    cfg_pattern = pat; cfg_period = PER_W'(per);
    cfg_lim_lo = DW'(lo); cfg_lim_hi = DW'(hi);
    if (fmode == 3) glitch_at = cyc + 2 + 3 * per + per / 2;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    while (n < nn + 50) begin
      @(posedge clk); #1;
      n++;
      if (n < nn && excite_o !== lv[n / per]) seq_ok = 0;
      if (poke && n == 5) begin
        start = 1'b1; cfg_pattern = ~pat; cfg_period = PER_W'(per + 3);
      end
      if (poke && n == 6) start = 1'b0;
      if (done_o) break;
    end
    // R2 latency and sequence; R3 when poked
    chk(n == nn + 1, poke ? "R3 latency" : "R2 latency", n, nn + 1);
    chk(seq_ok, poke ? "R3 sequence" : "R2 sequence", seq_ok, 1);
    // R6 R7 R8 verdict
    chk(pass_o == pexp, tmo ? "R6 verdict" : (fmode != 0 ? "R7 verdict" : "R8 verdict"),
        pass_o, pexp);
    if (!tmo && fmode == 0) begin
      chk(delay_rise_o == DW'(rexp), "R4/R5 rise", delay_rise_o, rexp);
      chk(delay_fall_o == DW'(fexp), "R4/R5 fall", delay_fall_o, fexp);
      chk(delay_o == DW'(wexp), "R5 worst", delay_o, wexp);
    end
    p_keep = pass_o; d_keep = delay_o;
    repeat (6) @(posedge clk); #1;
    // R10 results hold
    chk(pass_o == p_keep && delay_o == DW'(d_keep), "R10 hold", delay_o, d_keep);
    glitch_at = -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    chk(!excite_o && !busy_o && !done_o && !pass_o, "R1 flags", {excite_o, busy_o, done_o, pass_o}, 0);
    chk(delay_o == 0 && delay_rise_o == 0 && delay_fall_o == 0, "R1 delays", delay_o, 0);
    // R4 symmetric sweep up to the timeout boundary
    for (int d = 0; d <= 23; d++) run_test(8'b0110_0101, 8, 0, 1023, d, d, 0, 0);
    // R6 first delay past the boundary
    run_test(8'b0110_0101, 8, 0, 1023, 24, 3, 0, 0);
    run_test(8'b0110_0101, 4, 0, 1023, 7, 7, 0, 0);
    run_test(8'b0110_0101, 4, 0, 1023, 8, 2, 0, 0);
    // R5 asymmetric rise/fall
    for (int a = 0; a <= 20; a += 5)
      for (int b = 0; b <= 20; b += 5) run_test(8'hA5, 8, 0, 1023, a, b, 0, 0);
    // R5 R8 every pattern
    for (int p = 0; p < 256; p++) run_test(8'(p), 8, 0, 1023, 6, 9, 0, 0);
    // R8 limits
    run_test(8'h3C, 8, 13, 13, 13, 10, 0, 0);
    run_test(8'h3C, 8, 14, 1023, 13, 10, 0, 0);
    run_test(8'h3C, 8, 0, 12, 13, 10, 0, 0);
    // R7 inverted line and glitch; R6 stuck line
    run_test(8'h3C, 8, 0, 1023, 5, 5, 2, 0);
    run_test(8'h00, 8, 0, 1023, 2, 2, 0, 0);
    run_test(8'h0F, 8, 0, 1023, 2, 2, 3, 0);
    run_test(8'h3C, 8, 0, 1023, 5, 5, 1, 0);
    // R3 start and config ignored while busy
    run_test(8'h96, 10, 0, 1023, 11, 17, 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule